// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

The block is a timer/counter that ramps from zero up to a programmable ceiling, turns round, and ramps back to zero. Several compare channels watch the count. Each channel drives a pulse-width-modulated output that changes level when the count meets the channel's threshold. One level applies on the rising ramp and the opposite level applies on the falling ramp. The period ceiling comes from one of two places, selected by a configuration input. The first is the buffered threshold of channel 0, which suits a period that changes at run time. The second is a separate ceiling register that takes effect at once, which leaves channel 0 free to produce its own waveform.

Software writes thresholds into shadow registers. The live thresholds, and with them a ceiling taken from channel 0, are refreshed only while the count sits at zero. Because of this, the rising and falling halves of every period are equal, and the pulses stay centred even while they are being retuned. Sticky flags mark the zero point, the ceiling and each channel match. Software clears a flag by writing a one to its bit. Counting advances only on cycles in which the tick-enable input is high, and a prescaler outside the block drives that input.

Top module: `dspwm_timer`

## Requirements
- R1: Once reset has been released, the count is 0 and the counter heads upward. All shadow thresholds, live thresholds, the ceiling register, the flags and the waveform state are 0, and with every output-enable low all pins read 0.
- R2: The count changes only on cycles with `tick_en` high, and by one step at a time. It rises from 0 to the ceiling, stays at the ceiling for exactly one tick, then falls back to 0 and rises again.
- R3: A write to address i (0 to 2) stores the value in the shadow of channel i. Live thresholds are copied from the shadows only on a tick taken while the count is 0. A threshold written in mid-period therefore takes effect in the following period.
- R4: The overflow flag, bit 4 of `flags_o`, sets on the same tick in which the shadows are copied at count 0.
- R5: With `top_sel` = 0, the ceiling is the live threshold of channel 0. With `top_sel` = 1, the ceiling is the ceiling register, written at address 3, and a new value there applies from the next cycle.
- R6: With `top_sel` = 1, flag bit 3 sets on the tick taken at the ceiling while the count is rising. With `top_sel` = 0, channel 0's match flag, bit 0, sets at the ceiling instead.
- R7: Flag bit i (0 to 2) sets on any tick in which the count equals channel i's live threshold and that threshold does not exceed the ceiling.
- R8: Each channel has a mode field `cmp_mode[2i+1:2i]`. In mode 2, a match reached while rising drives the waveform low and a match reached while falling drives it high. Mode 3 does the opposite. In modes 0 and 1, the pin carries `port_val[i]` instead of the waveform.
- R9: A channel whose live threshold exceeds the ceiling never matches. Its flag does not set and its waveform holds its level.
- R10: `pin_o[i]` is 0 whenever `out_en[i]` is low, whatever the mode or waveform.
- R11: Writing to address 4 clears each flag whose bit in the written data is 1. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count advance enable, one cycle per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-2 shadow thresholds, 3 ceiling register, 4 flag clear |
| wr_data | input | 16 | Write data |
| top_sel | input | 1 | Ceiling source: 0 channel 0 threshold, 1 ceiling register |
| cmp_mode | input | 6 | Two-bit waveform mode per channel |
| out_en | input | 3 | Per-pin output enable |
| port_val | input | 3 | Plain port level shown in modes 0 and 1 |
| count_o | output | 16 | Current count |
| flags_o | output | 5 | Sticky flags: [2:0] matches, [3] ceiling, [4] overflow |
| pin_o | output | 3 | Gated pin levels |

## Verification
The hardest case to reach is a clash between events: a shadow write, or a flag-clear write, that lands on the very tick in which the count sits at zero or at the ceiling. A clear that meets a set must lose, and a write that meets the copy must miss it. The stimulus pairs long free-running stretches, with gaps in `tick_en`, with flag-clear writes on every third cycle. Over several periods these writes fall on each phase of the count, including the zero and ceiling ticks. Retuning the thresholds and the ceiling register in mid-period checks that a change is deferred or applied at once according to the ceiling source.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

  typedef enum logic [1:0] {
    WAVE_OFF    = 2'd0,
    WAVE_RSVD   = 2'd1,
    WAVE_NONINV = 2'd2,
    WAVE_INV    = 2'd3
  } wave_mode_e;

endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          bot_evt_o,
  output logic          top_evt_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick_en) begin
      if (up_q) begin
        if (cnt_q < top_val) begin
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
          up_d  = 1'b0;
        end
      end else begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          up_d = 1'b1;
          if (top_val != '0) cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign up_o      = up_q;
  assign bot_evt_o = tick_en && (cnt_q == '0);
  assign top_evt_o = tick_en && up_q && (cnt_q == top_val);

  // R2: no tick, no movement
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q) && $stable(up_q));

  // R2: one step at a time
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)
                || (cnt_q == $past(cnt_q)));

  // R2: with a nonzero ceiling every tick moves the count
  a_r2_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && top_val != '0) |=> cnt_q != $past(cnt_q));

endmodule

// File: rtl/dspwm_regs.sv
module dspwm_regs #(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 2),
  parameter int NF  = NCH + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    top_sel,
  input  logic                    bot_evt,
  input  logic                    top_evt,
  input  logic [NCH-1:0]          match,
  output logic [NCH-1:0][CW-1:0]  act_o,
  output logic [CW-1:0]           top_val_o,
  output logic [NF-1:0]           flags_o
);

  localparam int ADDR_FIX = NCH;
  localparam int ADDR_CLR = NCH + 1;
  localparam int F_TOP    = NCH;
  localparam int F_OVF    = NCH + 1;

  logic [NCH-1:0][CW-1:0] shd_q, shd_d;
  logic [NCH-1:0][CW-1:0] act_q;
  logic [CW-1:0]          fix_q, fix_d;
  logic [NF-1:0]          flg_q, flg_d, set_v, clr_v;
  logic                   fix_we;

  // shadow write decode, one lane per channel
  for (genvar i = 0; i < NCH; i++) begin : g_shd
    always_comb begin
      shd_d[i] = shd_q[i];
      if (wr_en && wr_addr == AW'(i)) shd_d[i] = wr_data;
    end
  end

  assign fix_we = wr_en && (wr_addr == AW'(ADDR_FIX));
  assign fix_d  = fix_we ? wr_data : fix_q;

  always_comb begin
    clr_v = '0;
    if (wr_en && wr_addr == AW'(ADDR_CLR)) clr_v = wr_data[NF-1:0];
    set_v              = '0;
    set_v[NCH-1:0]     = match;
    set_v[F_TOP]       = top_evt && top_sel;
    set_v[F_OVF]       = bot_evt;
    flg_d              = (flg_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      fix_q <= '0;
      flg_q <= '0;
    end else begin
      shd_q <= shd_d;
      fix_q <= fix_d;
      flg_q <= flg_d;
    end
  end

  // live thresholds refresh only at the zero point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (bot_evt) begin
      act_q <= shd_q;
    end
  end

  assign act_o     = act_q;
  assign top_val_o = top_sel ? fix_q : act_q[0];
  assign flags_o   = flg_q;

  // R3: live thresholds frozen away from the zero point
  a_r3_frozen_act: assert property (@(posedge clk) disable iff (!rst_n)
    !bot_evt |=> $stable(act_q));

  // R4: overflow flag at the zero tick
  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    bot_evt |=> flg_q[F_OVF]);

  // R6: ceiling flag when the ceiling register defines the period
  a_r6_top_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt && top_sel) |=> flg_q[F_TOP]);

  // R11: clear without a competing set drops the flag
  a_r11_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_CLR) && wr_data[F_OVF] && !bot_evt) |=> !flg_q[F_OVF]);

endmodule

// File: rtl/dspwm_chan.sv
module dspwm_chan
  import dspwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic [CW-1:0] act,
  input  logic [CW-1:0] top_val,
  input  logic [1:0]    mode,
  input  logic          oe,
  input  logic          port_val,
  output logic          match_o,
  output logic          pin_o
);

  wave_mode_e wmode;
  logic       wave_q, wave_d;

  assign wmode   = wave_mode_e'(mode);
  assign match_o = tick_en && (cnt == act) && (act <= top_val);

  always_comb begin
    wave_d = wave_q;
    if (match_o) begin
      case (wmode)
        WAVE_NONINV: wave_d = ~up;
        WAVE_INV:    wave_d = up;
        default:     wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  always_comb begin
    pin_o = 1'b0;
    if (oe) begin
      if (wmode == WAVE_NONINV || wmode == WAVE_INV) pin_o = wave_q;
      else                                          pin_o = port_val;
    end
  end

  // R8: rising match in non-inverted mode drives low
  a_r8_noninv_up: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && up && wmode == WAVE_NONINV) |=> !wave_q);

  // R8: falling match in inverted mode drives low
  a_r8_inv_down: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !up && wmode == WAVE_INV) |=> !wave_q);

  // R9: without a match the waveform holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |=> $stable(wave_q));

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer #(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 2),
  parameter int NF  = NCH + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic             top_sel,
  input  logic [2*NCH-1:0] cmp_mode,
  input  logic [NCH-1:0]   out_en,
  input  logic [NCH-1:0]   port_val,
  output logic [CW-1:0]    count_o,
  output logic [NF-1:0]    flags_o,
  output logic [NCH-1:0]   pin_o
);

  logic [1:0]             rst_sync_q;
  logic                   rst_i_n;
  logic [CW-1:0]          cnt;
  logic                   up;
  logic                   bot_evt, top_evt;
  logic [CW-1:0]          top_val;
  logic [NCH-1:0][CW-1:0] act;
  logic [NCH-1:0]         match;
  logic                   tick_g;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];
  assign tick_g  = tick_en && rst_i_n;

  dspwm_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick_en   (tick_g),
    .top_val   (top_val),
    .cnt_o     (cnt),
    .up_o      (up),
    .bot_evt_o (bot_evt),
    .top_evt_o (top_evt)
  );

  dspwm_regs #(.CW(CW), .NCH(NCH), .AW(AW), .NF(NF)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .top_sel   (top_sel),
    .bot_evt   (bot_evt),
    .top_evt   (top_evt),
    .match     (match),
    .act_o     (act),
    .top_val_o (top_val),
    .flags_o   (flags_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dspwm_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .tick_en  (tick_g),
      .cnt      (cnt),
      .up       (up),
      .act      (act[i]),
      .top_val  (top_val),
      .mode     (cmp_mode[2*i+1:2*i]),
      .oe       (out_en[i]),
      .port_val (port_val[i]),
      .match_o  (match[i]),
      .pin_o    (pin_o[i])
    );
  end

  assign count_o = cnt;

  // R10: a disabled pin is always low
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_en == '0) |-> (pin_o == '0));

endmodule

// File: tb/dspwm_timer_bench.sv
`timescale 1ns/1ps
module dspwm_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en, top_sel;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [5:0]  cmp_mode;
  logic [2:0]  out_en, port_val;
  logic [15:0] count_o;
  logic [4:0]  flags_o;
  logic [2:0]  pin_o;

  always #2.5 clk = ~clk;

  dspwm_timer u_dspwm_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .top_sel(top_sel),
    .cmp_mode(cmp_mode), .out_en(out_en), .port_val(port_val),
    .count_o(count_o), .flags_o(flags_o), .pin_o(pin_o)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic [4:0]  fl;
    logic [2:0]  pin;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // reference state
  logic [15:0] m_cnt, m_fix;
  logic        m_up;
  logic [15:0] m_shd [3];
  logic [15:0] m_act [3];
  logic [4:0]  m_fl;
  logic [2:0]  m_wave;

  function automatic logic [2:0] exp_pins();
    logic [2:0] p;
    for (int i = 0; i < 3; i++) begin
      if (!out_en[i])           p[i] = 1'b0;
      else if (cmp_mode[2*i+1]) p[i] = m_wave[i];
      else                      p[i] = port_val[i];
    end
    return p;
  endfunction

  task automatic model_edge();
    logic [15:0] top;
    logic [2:0]  hit;
    logic [4:0]  clr;
    logic        bot, tev;
    top = top_sel ? m_fix : m_act[0];
    bot = tick_en && (m_cnt == 16'd0);
    tev = tick_en && m_up && (m_cnt == top);
    for (int i = 0; i < 3; i++)
      hit[i] = tick_en && (m_cnt == m_act[i]) && (m_act[i] <= top);
    clr  = (wr_en && wr_addr == 3'd4) ? wr_data[4:0] : 5'd0;
    m_fl = (m_fl & ~clr) | {bot, tev && top_sel, hit};
    for (int i = 0; i < 3; i++)
      if (hit[i] && cmp_mode[2*i+1]) m_wave[i] = cmp_mode[2*i] ? m_up : ~m_up;
    if (bot) for (int i = 0; i < 3; i++) m_act[i] = m_shd[i];
    if (wr_en && wr_addr < 3'd3) m_shd[wr_addr] = wr_data;
    if (wr_en && wr_addr == 3'd3) m_fix = wr_data;
    if (tick_en) begin
      if (m_up) begin
        if (m_cnt < top) m_cnt = m_cnt + 16'd1;
        else if (m_cnt != 16'd0) begin m_cnt = m_cnt - 16'd1; m_up = 1'b0; end
      end else begin
        if (m_cnt != 16'd0) m_cnt = m_cnt - 16'd1;
        else begin m_up = 1'b1; if (top != 16'd0) m_cnt = m_cnt + 16'd1; end
      end
    end
  endtask

  // driver: apply one cycle of stimulus, then push the expected result
  task automatic step(input bit tk, input bit we, input logic [2:0] a,
                      input logic [15:0] d, input string tag);
    exp_t e;
    @(negedge clk); #1;
    tick_en = tk; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge();
    e.cnt = m_cnt; e.fl = m_fl; e.pin = exp_pins();
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic set_cfg(input logic sel, input logic [5:0] md,
                         input logic [2:0] oe, input logic [2:0] pv);
    @(negedge clk); #1;
    tick_en = 1'b0; wr_en = 1'b0;
    top_sel = sel; cmp_mode = md; out_en = oe; port_val = pv;
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step((k % 7) != 6, 1'b0, 3'd0, 16'd0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({count_o, flags_o, pin_o} !== e) begin
        n_bad++;
        $display("FAIL %s: cnt=%0d flags=%b pins=%b expected cnt=%0d flags=%b pins=%b",
                 t, count_o, flags_o, pin_o, e.cnt, e.fl, e.pin);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    top_sel = 1'b0; cmp_mode = '0; out_en = '0; port_val = '0;
    m_cnt = '0; m_fix = '0; m_up = 1'b1; m_fl = '0; m_wave = '0;
    for (int i = 0; i < 3; i++) begin m_shd[i] = '0; m_act[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if ({count_o, flags_o, pin_o} !== 24'd0) begin
      n_bad++;
      $display("FAIL R1: cnt=%0d flags=%b pins=%b expected all zero", count_o, flags_o, pin_o);
    end

    // ch0 non-inverted (ceiling), ch1 inverted, ch2 threshold above ceiling
    set_cfg(1'b0, {2'd2, 2'd3, 2'd2}, 3'b111, 3'b000);
    step(1'b0, 1'b1, 3'd0, 16'd6, "R3");
    step(1'b0, 1'b1, 3'd1, 16'd2, "R3");
    step(1'b0, 1'b1, 3'd2, 16'd9, "R9");
    run(40, "R2");
    step(1'b1, 1'b1, 3'd1, 16'd4, "R3");
    run(30, "R3");
    run(20, "R4/R7");
    for (int k = 0; k < 30; k++)
      step(1'b1, (k % 3) == 0, 3'd4, 16'h001f, "R11");

    // ceiling from the separate register; channel 0 becomes a plain PWM
    set_cfg(1'b1, {2'd2, 2'd3, 2'd2}, 3'b111, 3'b000);
    step(1'b1, 1'b1, 3'd3, 16'd5, "R5");
    step(1'b1, 1'b1, 3'd0, 16'd3, "R6");
    run(30, "R6");
    step(1'b1, 1'b1, 3'd3, 16'd8, "R5");
    run(30, "R5");
    step(1'b1, 1'b1, 3'd4, 16'h001f, "R11");
    run(20, "R9");

    set_cfg(1'b1, {2'd2, 2'd1, 2'd0}, 3'b111, 3'b101);
    run(12, "R8");
    set_cfg(1'b1, {2'd2, 2'd3, 2'd2}, 3'b010, 3'b111);
    run(12, "R10");
    set_cfg(1'b0, {2'd3, 2'd2, 2'd3}, 3'b111, 3'b000);
    run(30, "R8");

    @(negedge clk); #1; tick_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule